// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads a page directory entry and then a page table entry from memory through a single 32-bit memory port. Pages are 4 KB. It checks each entry for presence and for user/supervisor and read/write permission. When the accessed bit or the dirty bit has to change, it writes the updated entry back before it answers. A fault returns a three-bit error code and stores the linear address in a fault-address register.

The directory base is loaded through a write strobe. The low 12 bits of that base are always treated as zero. The block keeps the last successful translation in a one-entry cache. A repeated access to the same page can then be answered without touching memory, provided the access is allowed and needs no dirty update. Any write to the base register clears that entry.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0 and fault_addr is 0.
- R2: The directory entry is read at base + 4 * lin[31:22]. The table entry is read at {directory entry[31:12], 12'b0} + 4 * lin[21:12]. A successful response gives rsp_phys = {table entry[31:12], lin[11:0]}.
- R3: A directory entry with bit 0 (present) clear ends the walk with a fault. No table entry is read, nothing is written, and fault_addr takes the linear address.
- R4: A table entry with bit 0 clear ends the walk with a fault, and fault_addr takes the linear address.
- R5: A user access (req_user = 1) faults when bit 2 (user) is clear in either entry. A supervisor access ignores bit 2.
- R6: A user write faults when bit 1 (writable) is clear in either entry. A supervisor write ignores bit 1.
- R7: On success, an entry whose bit 5 (accessed) is clear is written back with bit 5 set, and all other bits keep their values. An entry whose bit 5 is already set is not written.
- R8: On a successful write access, a table entry with bit 6 (dirty) clear is written back with bits 6 and 5 set. A read access never sets bit 6.
- R9: The error code rsp_err has bit 0 = 1 for a protection fault and 0 for a not-present fault, bit 1 = req_write, and bit 2 = req_user.
- R10: A faulting walk writes nothing to memory.
- R11: A later access to the same page as the last successful walk is answered with no memory access. This holds when that access is permitted by the combined rights and is a read or targets a page already marked dirty. A write to a clean cached page walks again.
- R12: Writing the base register invalidates the held translation, so the next access walks in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Directory base write strobe |
| base_wdata | input | 32 | New directory base (low 12 bits ignored) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-level access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_err | output | 3 | Fault error code |
| rsp_phys | output | 32 | Physical address |
| fault_addr | output | 32 | Last faulting linear address |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Entry write data |
| mem_ack | input | 1 | Memory access done |
| mem_rdata | input | 32 | Entry read data |

## Verification
The hardest case is a write to a page that already sits in the one-entry cache but is still clean. The response alone looks the same as a hit. Only the memory traffic shows that the walker went back to set the dirty bit. The bench first makes a read that fills the cache, then writes the same page, and counts reads and writes at its memory model. A second write to the same page must then produce no traffic, and a base register rewrite must bring the full walk back.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_err,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata
);
  localparam int FRM_W = ADDR_W - OFS_W;
  localparam int TOP   = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] BASE_MASK = {{FRM_W{1'b1}}, {OFS_W{1'b0}}};
  localparam int B_P = 0, B_RW = 1, B_US = 2, B_A = 5, B_D = 6;

  typedef enum logic [2:0] {IDLE, RD_DIR, RD_TBL, WR_DIR, WR_TBL, DONE} st_t;
  st_t st;

  logic [ADDR_W-1:0] base_q, lin_q, dir_q, tbl_q, dir_addr_q;
  logic              wr_q, usr_q;
  logic              c_vld, c_rw, c_us, c_dirty;
  logic [FRM_W-1:0]  c_tag, c_frm;

  logic hit, us_ok, rw_ok, pres, bad, need_dir, need_tbl;
  logic [ADDR_W-1:0] tbl_addr;

  assign req_ready = (st == IDLE);
  assign rsp_valid = (st == DONE);
  assign mem_req   = (st == RD_DIR) || (st == RD_TBL) || (st == WR_DIR) || (st == WR_TBL);
  assign mem_we    = (st == WR_DIR) || (st == WR_TBL);
  assign mem_wdata = (st == WR_DIR) ? (dir_q | (ADDR_W'(1) << B_A))
                   : (tbl_q | (ADDR_W'(1) << B_A) | (ADDR_W'(wr_q) << B_D));

  assign hit = c_vld && (c_tag == req_lin[TOP:OFS_W])
            && (!req_user || (c_us && (!req_write || c_rw)))
            && (!req_write || c_dirty);

  assign tbl_addr = {dir_q[TOP:OFS_W], {OFS_W{1'b0}}}
                  + {{(ADDR_W-IDX_W-2){1'b0}}, lin_q[OFS_W+IDX_W-1:OFS_W], 2'b00};
  assign pres     = mem_rdata[B_P];
  assign us_ok    = !usr_q || (dir_q[B_US] && mem_rdata[B_US]);
  assign rw_ok    = !usr_q || !wr_q || (dir_q[B_RW] && mem_rdata[B_RW]);
  assign bad      = !pres || !us_ok || !rw_ok;
  assign need_dir = !dir_q[B_A];
  assign need_tbl = !mem_rdata[B_A] || (wr_q && !mem_rdata[B_D]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      base_q <= '0; lin_q <= '0; dir_q <= '0; tbl_q <= '0; dir_addr_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0;
      c_vld <= 1'b0; c_rw <= 1'b0; c_us <= 1'b0; c_dirty <= 1'b0;
      c_tag <= '0; c_frm <= '0;
      rsp_fault <= 1'b0; rsp_err <= '0; rsp_phys <= '0; fault_addr <= '0;
      mem_addr <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          lin_q <= req_lin; wr_q <= req_write; usr_q <= req_user;
          if (hit) begin
            rsp_fault <= 1'b0; rsp_err <= '0;
            rsp_phys <= {c_frm, req_lin[OFS_W-1:0]};
            st <= DONE;
          end else begin
            mem_addr <= (base_q & BASE_MASK)
                      + {{(ADDR_W-IDX_W-2){1'b0}}, req_lin[TOP:TOP-IDX_W+1], 2'b00};
            dir_addr_q <= (base_q & BASE_MASK)
                      + {{(ADDR_W-IDX_W-2){1'b0}}, req_lin[TOP:TOP-IDX_W+1], 2'b00};
            st <= RD_DIR;
          end
        end
        RD_DIR: if (mem_ack) begin
          dir_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            rsp_fault <= 1'b1; rsp_err <= {usr_q, wr_q, 1'b0};
            fault_addr <= lin_q; st <= DONE;
          end else begin
            mem_addr <= {mem_rdata[TOP:OFS_W], {OFS_W{1'b0}}}
                      + {{(ADDR_W-IDX_W-2){1'b0}}, lin_q[OFS_W+IDX_W-1:OFS_W], 2'b00};
            st <= RD_TBL;
          end
        end
        RD_TBL: if (mem_ack) begin
          tbl_q <= mem_rdata;
          if (bad) begin
            rsp_fault <= 1'b1; rsp_err <= {usr_q, wr_q, pres};
            fault_addr <= lin_q; st <= DONE;
          end else begin
            rsp_fault <= 1'b0; rsp_err <= '0;
            rsp_phys <= {mem_rdata[TOP:OFS_W], lin_q[OFS_W-1:0]};
            c_vld <= 1'b1; c_tag <= lin_q[TOP:OFS_W]; c_frm <= mem_rdata[TOP:OFS_W];
            c_rw <= dir_q[B_RW] && mem_rdata[B_RW];
            c_us <= dir_q[B_US] && mem_rdata[B_US];
            c_dirty <= mem_rdata[B_D] || wr_q;
            if (need_dir) begin
              mem_addr <= dir_addr_q; st <= WR_DIR;
            end else if (need_tbl) begin
              st <= WR_TBL;
            end else begin
              st <= DONE;
            end
          end
        end
        WR_DIR: if (mem_ack) begin
          if (!tbl_q[B_A] || (wr_q && !tbl_q[B_D])) begin
            mem_addr <= tbl_addr; st <= WR_TBL;
          end else begin
            st <= DONE;
          end
        end
        WR_TBL: if (mem_ack) st <= DONE;
        default: st <= IDLE;
      endcase
      if (base_we) begin
        base_q <= base_wdata;
        c_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_lin,
  input logic        req_write,
  input logic        req_user,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [2:0]  rsp_err,
  input logic [31:0] rsp_phys,
  input logic [31:0] fault_addr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  logic [31:0] lin_s;
  logic        wr_s, usr_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_s <= '0; wr_s <= 1'b0; usr_s <= 1'b0;
    end else if (req_valid && req_ready) begin
      lin_s <= req_lin; wr_s <= req_write; usr_s <= req_user;
    end
  end

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_phys[11:0] == lin_s[11:0]);
  // R2
  rsp_idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req && !req_ready);
  // R3
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> fault_addr == lin_s);
  // R9
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_err[1] == wr_s && rsp_err[2] == usr_s);
  // R5
  sup_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault && !usr_s |-> !rsp_err[0]);
  // R7
  wb_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5]);
  // R8
  rd_no_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !wr_s |-> !$rose(mem_wdata[6]));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
  .rsp_phys(rsp_phys), .fault_addr(fault_addr), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic base_we = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] base_wdata = '0, req_lin = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_req, mem_we;
  logic [2:0] rsp_err;
  logic [31:0] rsp_phys, fault_addr, mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  pt_walker u0 (.*);

  logic [31:0] mem [logic [31:0]];
  int nrd = 0, nwr = 0, checks = 0, errors = 0, cyc = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin mem[mem_addr] = mem_wdata; nwr++; end
      else begin mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0; nrd++; end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); base_we = 1'b1; base_wdata = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] lin, input bit wr, input bit usr);
    int n = 0;
    @(negedge clk);
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    nrd = 0; nwr = 0;
    req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
    @(negedge clk); req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (!rsp_valid) chk(0, "timeout", 0, 1);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R1 idle outputs",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    chk(fault_addr === 32'h0, "R1 fault_addr", fault_addr, 0);
  endtask

  task automatic t_first_walk;
    xlate(32'h0040_3ABC, 0, 0);
    chk(!rsp_fault && rsp_phys == 32'h0055_5ABC, "R2 phys", rsp_phys, 32'h0055_5ABC);
    chk(nrd == 2 && nwr == 2, "R7 traffic rd/wr", nrd * 16 + nwr, 32'h22);
    chk(rdm(32'h0001_0004) == 32'h0002_0027, "R7 dir accessed", rdm(32'h0001_0004), 32'h0002_0027);
    chk(rdm(32'h0002_000C) == 32'h0055_5027, "R8 read leaves dirty", rdm(32'h0002_000C), 32'h0055_5027);
  endtask

  task automatic t_cache;
    xlate(32'h0040_3010, 0, 1);
    chk(!rsp_fault && rsp_phys == 32'h0055_5010 && nrd == 0 && nwr == 0, "R11 read hit",
        rsp_phys, 32'h0055_5010);
    xlate(32'h0040_3020, 1, 1);
    chk(!rsp_fault && rsp_phys == 32'h0055_5020, "R8 write phys", rsp_phys, 32'h0055_5020);
    chk(nrd == 2 && nwr == 1, "R11 clean write walks", nrd * 16 + nwr, 32'h21);
    chk(rdm(32'h0002_000C) == 32'h0055_5067, "R8 dirty set", rdm(32'h0002_000C), 32'h0055_5067);
    xlate(32'h0040_3030, 1, 1);
    chk(!rsp_fault && nrd == 0 && nwr == 0, "R11 dirty write hit", nrd * 16 + nwr, 0);
  endtask

  task automatic t_invalidate;
    set_base(32'h0001_0ABC);
    xlate(32'h0040_3040, 0, 0);
    chk(!rsp_fault && rsp_phys == 32'h0055_5040, "R12 phys", rsp_phys, 32'h0055_5040);
    chk(nrd == 2 && nwr == 0, "R12 full walk, R7 no rewrite", nrd * 16 + nwr, 32'h20);
  endtask

  task automatic t_not_present;
    xlate(32'h0080_0123, 1, 1);
    chk(rsp_fault && rsp_err == 3'b110, "R3 R9 dir fault err", rsp_err, 3'b110);
    chk(nrd == 1 && nwr == 0, "R3 one read", nrd * 16 + nwr, 32'h10);
    chk(fault_addr == 32'h0080_0123, "R3 fault_addr", fault_addr, 32'h0080_0123);
    xlate(32'h0040_4567, 0, 0);
    chk(rsp_fault && rsp_err == 3'b000, "R4 R9 tbl fault err", rsp_err, 0);
    chk(fault_addr == 32'h0040_4567, "R4 fault_addr", fault_addr, 32'h0040_4567);
    xlate(32'h00C0_0000, 0, 0);
    chk(rsp_fault && nwr == 0, "R10 no write on fault", nwr, 0);
    chk(rdm(32'h0001_000C) == 32'h0003_0007, "R10 dir untouched", rdm(32'h0001_000C), 32'h0003_0007);
  endtask

  task automatic t_protect;
    xlate(32'h0040_5123, 0, 1);
    chk(rsp_fault && rsp_err == 3'b101, "R5 user on sup page", rsp_err, 3'b101);
    chk(rdm(32'h0002_0014) == 32'h0077_7003, "R10 tbl untouched", rdm(32'h0002_0014), 32'h0077_7003);
    xlate(32'h0040_5123, 0, 0);
    chk(!rsp_fault && rsp_phys == 32'h0077_7123, "R5 sup ok", rsp_phys, 32'h0077_7123);
    xlate(32'h0040_6FF0, 1, 1);
    chk(rsp_fault && rsp_err == 3'b111, "R6 user write ro", rsp_err, 3'b111);
    xlate(32'h0040_6FF0, 1, 0);
    chk(!rsp_fault && rsp_phys == 32'h0088_8FF0, "R6 sup write ro", rsp_phys, 32'h0088_8FF0);
    chk(rdm(32'h0002_0018) == 32'h0088_8065, "R8 sup write dirty", rdm(32'h0002_0018), 32'h0088_8065);
    xlate(32'h0040_6004, 0, 1);
    chk(!rsp_fault && rsp_phys == 32'h0088_8004, "R6 user read ro", rsp_phys, 32'h0088_8004);
  endtask

  initial begin
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_000C] = 32'h0055_5007;
    mem[32'h0002_0014] = 32'h0077_7003;
    mem[32'h0002_0018] = 32'h0088_8005;
    mem[32'h0001_000C] = 32'h0003_0007;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    set_base(32'h0001_0000);
    t_first_walk;
    t_cache;
    t_invalidate;
    t_not_present;
    t_protect;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule